// File: doc/BRIEF.md
# SMBus Response Stall Watchdog

This block guards an SMBus master against a transaction that never completes. Two faults are covered: the addressed device never acknowledges, or a device holds the clock low for too long. Once the bit engine has shifted out its final bit and is waiting for the far side to respond, the block counts pulses of a slow reference tick. When the count reaches the limit, the block raises a one-cycle abort command so the bit engine drops the cycle. It also sets a sticky device-error flag.

Counting pauses while the byte-done status is set, and while the system-lockup indication is low. A pause keeps the partial count. Counting resumes from that value once both inhibits lift. The count returns to zero whenever the wait for a response ends. The bit engine can also report a missing acknowledge directly, and that report sets the same device-error flag. Software clears the flag with a write-one-to-clear strobe. The tick is a single-cycle enable in the system clock domain, so the whole block runs on one clock.

Top module: `smb_stall_watchdog`

## Requirements
- R1: Two outputs are 0 after synchronous reset: `dev_err` and `abort_pulse`.
- R2: A qualifying tick is a cycle with all four of these conditions: `tick_en`=1, `await_rsp`=1, `byte_done`=0 and `lockup_ind`=1. `abort_pulse` is 1 for exactly one clock. It is registered at the edge that samples the LIMIT-th qualifying tick (LIMIT defaults to 800).
- R3: While `byte_done`=1, ticks do not advance the count, and the count already held is kept.
- R4: While `lockup_ind`=0, ticks do not advance the count, and the count already held is kept.
- R5: Any cycle with `await_rsp`=0 returns the count to zero. Ticks seen while `await_rsp`=0 are not counted.
- R6: Within one unbroken wait period, at most one abort pulse occurs. Further ticks after expiry produce no more pulses.
- R7: Expiry sets `dev_err` at the same edge as the abort pulse. `dev_err` then stays 1 until it is cleared.
- R8: `nack_evt`=1 sets `dev_err` at the next edge and does not produce an abort pulse.
- R9: `err_clr`=1 clears `dev_err` at the next edge. The clear wins over an expiry or `nack_evt` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Single-cycle reference tick enable |
| await_rsp | input | 1 | Bit engine has sent its last bit and waits for a response |
| byte_done | input | 1 | Byte-done status; inhibits counting |
| lockup_ind | input | 1 | System-lockup indication; counting only while 1 |
| nack_evt | input | 1 | Missing acknowledge reported by the bit engine |
| err_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| dev_err | output | 1 | Sticky device-error flag |
| abort_pulse | output | 1 | One-cycle command to abandon the cycle |

## Verification
The bench probes the off-by-one edge of expiry. It applies one tick fewer than the limit, then exactly the limit. A comparator placed one count early or one count late would pulse at the wrong tick. The bench also inserts long inhibit spans in the middle of a count. A design that cleared the count instead of holding it would expire far too late, and one that ignored an inhibit would expire too early. Other cases cover the following:
- a brief drop of the wait signal just before expiry, which must restart the count;
- ticks continuing after expiry, which must not re-fire the abort pulse;
- a clear arriving in the same cycle as a set, where a design with the wrong priority would leave the flag set.

// File: rtl/smbto_pkg.sv
package smbto_pkg;

    localparam int unsigned DEF_LIMIT = 800;

    typedef struct packed {
        logic zero;     // wait ended: drop the count
        logic advance;  // qualifying tick this cycle
    } cnt_ctl_t;

    typedef struct packed {
        logic set_err;
        logic clr_err;
        logic expire;
    } flag_ev_t;

    function automatic cnt_ctl_t qualify(input logic tick, input logic wait_rsp,
                                         input logic bdone, input logic lock);
        cnt_ctl_t c;
        c.zero    = !wait_rsp;
        c.advance = tick && wait_rsp && !bdone && lock;
        return c;
    endfunction

endpackage

// File: rtl/smbto_gate.sv
module smbto_gate
    import smbto_pkg::*;
(
    input  logic     tick_en,
    input  logic     await_rsp,
    input  logic     byte_done,
    input  logic     lockup_ind,
    output cnt_ctl_t ctl
);
    always_comb ctl = qualify(tick_en, await_rsp, byte_done, lockup_ind);
endmodule

// File: rtl/smbto_counter.sv
module smbto_counter
    import smbto_pkg::*;
#(
    parameter int unsigned LIMIT = DEF_LIMIT
) (
    input  logic     clk,
    input  logic     rst,
    input  cnt_ctl_t ctl,
    input  logic     await_rsp,
    input  logic     inhibit,
    output logic     expire
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);

    logic [CW-1:0] cnt;
    logic          room;

    always_comb begin
        room   = (cnt < TOP);
        expire = ctl.advance && (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.zero)             cnt <= '0;
        else if (ctl.advance && room)    cnt <= cnt + 1'b1;
    end

    // count never passes the limit
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);
    // idle wait returns count to zero
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !await_rsp |=> cnt == '0);
    // inhibited count is frozen (covers both byte-done and lockup gates)
    p_hold_r3_r4: assert property (@(posedge clk) disable iff (rst)
        (await_rsp && inhibit) |=> $stable(cnt));
endmodule

// File: rtl/smbto_errflag.sv
module smbto_errflag
    import smbto_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  flag_ev_t ev,
    output logic     dev_err,
    output logic     abort_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dev_err     <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            abort_pulse <= ev.expire;
            if (ev.clr_err)                   dev_err <= 1'b0;
            else if (ev.set_err || ev.expire) dev_err <= 1'b1;
        end
    end

    p_clr_wins_r9: assert property (@(posedge clk) disable iff (rst)
        ev.clr_err |=> !dev_err);
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (dev_err && !ev.clr_err) |=> dev_err);
    p_abort_one_r2: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> !abort_pulse);
endmodule

// File: rtl/smb_stall_watchdog.sv
module smb_stall_watchdog
    import smbto_pkg::*;
#(
    parameter int unsigned LIMIT = DEF_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic await_rsp,
    input  logic byte_done,
    input  logic lockup_ind,
    input  logic nack_evt,
    input  logic err_clr,
    output logic dev_err,
    output logic abort_pulse
);
    cnt_ctl_t ctl;
    flag_ev_t ev;
    logic     expire;

    smbto_gate u_gate (
        .tick_en   (tick_en),
        .await_rsp (await_rsp),
        .byte_done (byte_done),
        .lockup_ind(lockup_ind),
        .ctl       (ctl)
    );

    smbto_counter #(.LIMIT(LIMIT)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .await_rsp(await_rsp),
        .inhibit  (byte_done || !lockup_ind),
        .expire   (expire)
    );

    always_comb begin
        ev.expire  = expire;
        ev.set_err = nack_evt;
        ev.clr_err = err_clr;
    end

    smbto_errflag u_flag (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .dev_err    (dev_err),
        .abort_pulse(abort_pulse)
    );

    // an abort always coincides with the flag unless a clear landed
    p_abort_flags_r7: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> (dev_err || $past(err_clr)));
    p_nack_sets_r8: assert property (@(posedge clk) disable iff (rst)
        (nack_evt && !err_clr) |=> dev_err);
endmodule

// File: tb/smb_stall_watchdog_tb.sv
module smb_stall_watchdog_tb;
    localparam int LIM = 800;

    logic clk = 1'b0;
    logic rst, tick_en, await_rsp, byte_done, lockup_ind, nack_evt, err_clr;
    logic dev_err, abort_pulse;
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc   = 0;

    always #2 clk = ~clk;  // 250 MHz

    smb_stall_watchdog #(.LIMIT(LIM)) u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .await_rsp(await_rsp),
        .byte_done(byte_done), .lockup_ind(lockup_ind), .nack_evt(nack_evt),
        .err_clr(err_clr), .dev_err(dev_err), .abort_pulse(abort_pulse)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic settle();
        await_rsp = 1'b0; byte_done = 1'b0; lockup_ind = 1'b1;
        nack_evt = 1'b0; err_clr = 1'b1;
        idle(1);
        err_clr = 1'b0;
        idle(1);
    endtask

    task automatic t_reset();
        chk(dev_err, 1'b0, "R1 dev_err");
        chk(abort_pulse, 1'b0, "R1 abort");
    endtask

    task automatic t_basic();
        settle();
        ticks(20);                        // not waiting: ignored (R5)
        await_rsp = 1'b1;
        ticks(LIM - 1);
        chk(abort_pulse, 1'b0, "R2 early");
        chk(dev_err, 1'b0, "R5 idle ticks");
        ticks(1);
        chk(abort_pulse, 1'b1, "R2 expiry");
        chk(dev_err, 1'b1, "R7 set");
        idle(1);
        chk(abort_pulse, 1'b0, "R2 one cycle");
        ticks(LIM + 10);
        chk(abort_pulse, 1'b0, "R6 no refire");
        chk(dev_err, 1'b1, "R7 sticky");
    endtask

    task automatic t_gate_bd();
        settle();
        await_rsp = 1'b1;
        ticks(500);
        byte_done = 1'b1;
        ticks(400);
        chk(abort_pulse, 1'b0, "R3 gated");
        chk(dev_err, 1'b0, "R3 gated err");
        byte_done = 1'b0;
        ticks(LIM - 501);
        chk(abort_pulse, 1'b0, "R3 held early");
        ticks(1);
        chk(abort_pulse, 1'b1, "R3 held resume");
    endtask

    task automatic t_gate_lock();
        settle();
        await_rsp = 1'b1;
        ticks(300);
        lockup_ind = 1'b0;
        ticks(600);
        chk(abort_pulse, 1'b0, "R4 gated");
        lockup_ind = 1'b1;
        ticks(LIM - 301);
        chk(abort_pulse, 1'b0, "R4 held early");
        ticks(1);
        chk(abort_pulse, 1'b1, "R4 held resume");
    endtask

    task automatic t_restart();
        settle();
        await_rsp = 1'b1;
        ticks(LIM - 1);
        await_rsp = 1'b0;
        idle(1);
        await_rsp = 1'b1;
        ticks(LIM - 1);
        chk(abort_pulse, 1'b0, "R5 restarted");
        chk(dev_err, 1'b0, "R5 restarted err");
        ticks(1);
        chk(abort_pulse, 1'b1, "R5 expiry after restart");
    endtask

    task automatic t_nack_clr();
        settle();
        nack_evt = 1'b1;
        idle(1);
        nack_evt = 1'b0;
        chk(dev_err, 1'b1, "R8 nack sets");
        chk(abort_pulse, 1'b0, "R8 no abort");
        idle(3);
        chk(dev_err, 1'b1, "R7 nack sticky");
        nack_evt = 1'b1; err_clr = 1'b1;
        idle(1);
        nack_evt = 1'b0; err_clr = 1'b0;
        chk(dev_err, 1'b0, "R9 clear wins nack");
        await_rsp = 1'b1;
        ticks(LIM - 1);
        tick_en = 1'b1; err_clr = 1'b1;
        idle(1);
        tick_en = 1'b0; err_clr = 1'b0;
        chk(abort_pulse, 1'b1, "R9 abort with clear");
        chk(dev_err, 1'b0, "R9 clear wins expiry");
    endtask

    initial begin
        rst = 1'b1; tick_en = 1'b0; await_rsp = 1'b0; byte_done = 1'b0;
        lockup_ind = 1'b1; nack_evt = 1'b0; err_clr = 1'b0;
        idle(3);
        t_reset();
        rst = 1'b0;
        idle(1);
        t_reset();
        t_basic();
        t_gate_bd();
        t_gate_lock();
        t_restart();
        t_nack_clr();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule